// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Read Pipeline

This block is a true two-port static memory. Each port has its own clock and reset, so the two sides can run with unrelated phases. Every location can be reached from either side. On each rising edge of its clock, a port takes in its select pair, its direction bit, its address and its write data. A port is selected only when its active-low enable is low and its active-high enable is high. A selected port either stores a byte or fetches one.

Read data leaves a port in one of two ways. In flow-through mode, data appears right after the fetching edge. In pipelined mode, one extra register adds a cycle of latency. A static mode pin on each port picks the behaviour, and each port can change it at any time without affecting the other port. An asynchronous active-low output enable gates the bus. The tri-state bus is modelled as a data output plus a drive-enable flag.

The address for each port is supplied from outside the block, for example by a separate counter. The array holds 2^ADDR_W words of DATA_W bits. The full-size configuration uses ADDR_W = 15 and DATA_W = 8.

Top module: `dpram_dual`

## Requirements
- R1: A port counts as selected on an edge only when `x_ce0_n` is 0 and `x_ce1` is 1. An edge with either condition failing stores nothing. It also launches no read data, so in flow-through mode `x_dout_en` is 0 after that edge.
- R2: On a selected edge, `x_rw` = 0 stores `x_din` at `x_addr` and `x_rw` = 1 fetches the word at `x_addr`. All of these are sampled on the port's rising clock edge.
- R3: While `x_oe_n` is 1, `x_dout_en` is 0 and `x_dout` is 0, with no clock edge needed. When `x_oe_n` returns to 0, any launched data shows again at once.
- R4: With `x_pipe` = 0 (flow-through), a read sampled on edge n sets `x_dout_en` = 1 and `x_dout` to the word after edge n. This holds until the port's next edge.
- R5: With `x_pipe` = 1 (pipelined), the same read data and its drive flag appear after edge n+1. The data drives the bus only if edge n was a selected read.
- R6: The mode pin acts combinationally and separately on each port. Raising `x_pipe` between edges switches the output at once from the word launched by the last edge to the word launched by the edge before it.
- R7: A word written through either port can be read back through the other port, at any address up to 2^ADDR_W-1.
- R8: A read on the edge directly after a write to the same address, on the same port, returns the new word.
- R9: If one port writes an address on the same edge instant that the other port reads it, the reading port returns the word held before the write. A later read returns the new word.
- R10: After reset, both ports have `x_dout_en` = 0 and `x_dout` = 0 until a selected read is launched.
- R11: A write edge launches no read data. In flow-through mode `x_dout_en` is 0 after a write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_ce0_n | input | 1 | Port A enable, active low |
| a_ce1 | input | 1 | Port A enable, active high |
| a_rw | input | 1 | Port A direction: 1 read, 0 write |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A mode: 0 flow-through, 1 pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A read data (0 when not driven) |
| a_dout_en | output | 1 | Port A bus drive flag |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_ce0_n | input | 1 | Port B enable, active low |
| b_ce1 | input | 1 | Port B enable, active high |
| b_rw | input | 1 | Port B direction: 1 read, 0 write |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B mode: 0 flow-through, 1 pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | DATA_W | Port B write data |
| b_dout | output | DATA_W | Port B read data (0 when not driven) |
| b_dout_en | output | 1 | Port B bus drive flag |

## Verification
The bench targets a collision where one port writes an address while the other reads it on the same edge instant. A design that forwarded the new word, or that let the last writer of the previous edge win the wrong way, would return the new value instead of the old one. It also toggles the mode pin and the output enable between edges. This catches logic that latches the mode at the clock, which would show stale or early data, and an enable that waits for a clock, which would keep driving the bus. Deselected and write edges are mixed with reads in both modes. A pipeline that forgets whether the launching edge was a real read would drive stale bytes one cycle late. Random runs pulse either clock alone or both together. This exposes designs whose storage is wired to only one clock.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic {
        RD_FLOW = 1'b0,
        RD_PIPE = 1'b1
    } rd_mode_e;

    function automatic logic port_selected(input logic ce0_n, input logic ce1);
        return !ce0_n && ce1;
    endfunction

endpackage

// File: rtl/dpram_bank.sv
// One write-owned copy of the array plus its winner tag bits.
// INVERT = 0 makes this copy win by matching the peer tag, 1 by differing.
module dpram_bank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10,
    parameter bit INVERT = 1'b0
) (
    input  logic                   wr_clk,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   peer_tag,
    input  logic [1:0][ADDR_W-1:0] rd_addr,
    output logic [1:0][DATA_W-1:0] rd_data,
    output logic [1:0]             rd_tag
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];
    logic [DEPTH-1:0]  tag_q;

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            word_q[wr_addr] <= wr_data;
            tag_q[wr_addr]  <= peer_tag ^ INVERT;
        end
    end

    for (genvar r = 0; r < 2; r++) begin : g_rd
        assign rd_data[r] = word_q[rd_addr[r]];
        assign rd_tag[r]  = tag_q[rd_addr[r]];
    end

endmodule

// File: rtl/dpram_port.sv
// Per-port control: select decode, read launch and the optional extra stage.
module dpram_port
    import dpram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              rw,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    typedef struct packed {
        logic              v1;
        logic [DATA_W-1:0] d1;
        logic              v2;
        logic [DATA_W-1:0] d2;
    } stage_t;

    stage_t   st_d, st_q;
    logic     sel, rd_go;
    rd_mode_e mode;
    logic              launch_v;
    logic [DATA_W-1:0] launch_d;

    assign sel   = port_selected(ce0_n, ce1);
    assign rd_go = sel && rw;
    assign wr_en = sel && !rw;
    assign mode  = rd_mode_e'(pipe);

    always_comb begin
        st_d    = st_q;
        st_d.v1 = rd_go;
        st_d.d1 = rd_go ? mem_rdata : st_q.d1;
        st_d.v2 = st_q.v1;
        st_d.d2 = st_q.d1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        launch_v = (mode == RD_PIPE) ? st_q.v2 : st_q.v1;
        launch_d = (mode == RD_PIPE) ? st_q.d2 : st_q.d1;
        dout_en  = launch_v && !oe_n;
        dout     = dout_en ? launch_d : '0;
    end

    p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!dout_en && dout == '0));

    p_desel_flow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !pipe) |=> (pipe || !dout_en));

    p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pipe) |=> (pipe || !dout_en));

    p_desel_pipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && pipe) |-> ##2 (!pipe || !dout_en));

endmodule

// File: rtl/dpram_dual.sv
module dpram_dual #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              a_clk,
    input  logic              a_rst_n,
    input  logic              a_ce0_n,
    input  logic              a_ce1,
    input  logic              a_rw,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_dout_en,
    input  logic              b_clk,
    input  logic              b_rst_n,
    input  logic              b_ce0_n,
    input  logic              b_ce1,
    input  logic              b_rw,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_dout_en
);
    localparam int NPORT = 2;

    logic [NPORT-1:0] clk_v, rst_v, ce0_v, ce1_v, rw_v, oe_v, pipe_v, wr_v, en_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0][DATA_W-1:0] din_v, rdata_v, dout_v;
    logic [NPORT-1:0][NPORT-1:0][DATA_W-1:0] bank_data;
    logic [NPORT-1:0][NPORT-1:0]             bank_tag;

    assign clk_v  = {b_clk,   a_clk};
    assign rst_v  = {b_rst_n, a_rst_n};
    assign ce0_v  = {b_ce0_n, a_ce0_n};
    assign ce1_v  = {b_ce1,   a_ce1};
    assign rw_v   = {b_rw,    a_rw};
    assign oe_v   = {b_oe_n,  a_oe_n};
    assign pipe_v = {b_pipe,  a_pipe};
    assign addr_v = {b_addr,  a_addr};
    assign din_v  = {b_din,   a_din};

    for (genvar g = 0; g < NPORT; g++) begin : g_side
        dpram_bank #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .INVERT (g == 1)
        ) u_bank (
            .wr_clk   (clk_v[g]),
            .wr_en    (wr_v[g]),
            .wr_addr  (addr_v[g]),
            .wr_data  (din_v[g]),
            .peer_tag (bank_tag[1-g][g]),
            .rd_addr  (addr_v),
            .rd_data  (bank_data[g]),
            .rd_tag   (bank_tag[g])
        );

        // Matching tags: copy 0 holds the newest word, otherwise copy 1.
        assign rdata_v[g] = (bank_tag[0][g] == bank_tag[1][g]) ?
                            bank_data[0][g] : bank_data[1][g];

        dpram_port #(.DATA_W(DATA_W)) u_port (
            .clk       (clk_v[g]),
            .rst_n     (rst_v[g]),
            .ce0_n     (ce0_v[g]),
            .ce1       (ce1_v[g]),
            .rw        (rw_v[g]),
            .oe_n      (oe_v[g]),
            .pipe      (pipe_v[g]),
            .mem_rdata (rdata_v[g]),
            .wr_en     (wr_v[g]),
            .dout      (dout_v[g]),
            .dout_en   (en_v[g])
        );
    end

    assign a_dout    = dout_v[0];
    assign a_dout_en = en_v[0];
    assign b_dout    = dout_v[1];
    assign b_dout_en = en_v[1];

endmodule

// File: tb/dpram_dual_tb.sv
module dpram_dual_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic a_clk = 1'b0, b_clk = 1'b0, a_rst_n = 1'b0, b_rst_n = 1'b0;
    logic a_ce0_n, a_ce1, a_rw, a_oe_n, a_pipe, a_dout_en;
    logic b_ce0_n, b_ce1, b_rw, b_oe_n, b_pipe, b_dout_en;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_din, b_din, a_dout, b_dout;

    bit            pce0 [2], pce1 [2], prw [2], poe [2], ppipe [2];
    logic [AW-1:0] paddr [2];
    logic [DW-1:0] pdin [2];

    logic [DW-1:0] mdl [DEPTH];
    bit            mv1 [2], mv2 [2];
    logic [DW-1:0] md1 [2], md2 [2];
    int checks = 0, fails = 0;

    assign a_ce0_n = pce0[0];  assign b_ce0_n = pce0[1];
    assign a_ce1   = pce1[0];  assign b_ce1   = pce1[1];
    assign a_rw    = prw[0];   assign b_rw    = prw[1];
    assign a_oe_n  = poe[0];   assign b_oe_n  = poe[1];
    assign a_pipe  = ppipe[0]; assign b_pipe  = ppipe[1];
    assign a_addr  = paddr[0]; assign b_addr  = paddr[1];
    assign a_din   = pdin[0];  assign b_din   = pdin[1];

    dpram_dual #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .a_clk(a_clk), .a_rst_n(a_rst_n), .a_ce0_n(a_ce0_n), .a_ce1(a_ce1),
        .a_rw(a_rw), .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_addr(a_addr),
        .a_din(a_din), .a_dout(a_dout), .a_dout_en(a_dout_en),
        .b_clk(b_clk), .b_rst_n(b_rst_n), .b_ce0_n(b_ce0_n), .b_ce1(b_ce1),
        .b_rw(b_rw), .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_addr(b_addr),
        .b_din(b_din), .b_dout(b_dout), .b_dout_en(b_dout_en)
    );

    function automatic logic [DW-1:0] fill(input int a);
        return DW'(a * 37 + 11);
    endfunction

    task automatic drv(input int p, input bit c0, input bit c1, input bit rw,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
        pce0[p] = c0; pce1[p] = c1; prw[p] = rw; paddr[p] = ad; pdin[p] = d;
    endtask

    // Pulse the chosen clocks once; the reference model follows each edge.
    task automatic cycle(input bit ea, input bit eb);
        bit            go [2];
        logic [DW-1:0] rd [2];
        go[0] = ea; go[1] = eb;
        #(CLK_PERIOD/2);
        a_clk = ea; b_clk = eb;
        for (int p = 0; p < 2; p++) rd[p] = mdl[paddr[p]];
        for (int p = 0; p < 2; p++) begin
            if (go[p]) begin
                bit sel;
                sel = !pce0[p] && pce1[p];
                mv2[p] = mv1[p]; md2[p] = md1[p];
                mv1[p] = sel && prw[p];
                if (sel && prw[p]) md1[p] = rd[p];
            end
        end
        for (int p = 0; p < 2; p++)
            if (go[p] && !pce0[p] && pce1[p] && !prw[p]) mdl[paddr[p]] = pdin[p];
        #(CLK_PERIOD/2);
        a_clk = 1'b0; b_clk = 1'b0;
    endtask

    task automatic cmp(input int p, input string tag, input bit ee, input logic [DW-1:0] ed);
        logic          ge;
        logic [DW-1:0] gd;
        ge = (p == 0) ? a_dout_en : b_dout_en;
        gd = (p == 0) ? a_dout : b_dout;
        checks++;
        if (ge !== ee || gd !== ed) begin
            fails++;
            $display("FAIL %s port%0d: got en=%0b dout=%02h, expected en=%0b dout=%02h",
                     tag, p, ge, gd, ee, ed);
        end
    endtask

    task automatic chk(input int p, input string tag);
        bit            ee;
        logic [DW-1:0] ed;
        ee = !poe[p] && (ppipe[p] ? mv2[p] : mv1[p]);
        ed = ee ? (ppipe[p] ? md2[p] : md1[p]) : '0;
        cmp(p, tag, ee, ed);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL R4 watchdog expired: got hung run, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int p = 0; p < 2; p++) begin
            drv(p, 1'b1, 1'b0, 1'b1, '0, '0);
            poe[p] = 1'b0; ppipe[p] = 1'b0;
        end
        cycle(1'b1, 1'b1); cycle(1'b1, 1'b1);
        a_rst_n = 1'b1; b_rst_n = 1'b1;
        for (int p = 0; p < 2; p++) begin mv1[p] = 0; mv2[p] = 0; md1[p] = '0; md2[p] = '0; end
        cmp(0, "R10", 1'b0, '0);
        cmp(1, "R10", 1'b0, '0);

        // Prefill through port A
        for (int a = 0; a < 16; a++) begin
            drv(0, 1'b0, 1'b1, 1'b0, AW'(a), fill(a)); cycle(1'b1, 1'b0);
        end
        cmp(0, "R11", 1'b0, '0);
        drv(0, 1'b0, 1'b1, 1'b0, AW'(DEPTH-1), fill(DEPTH-1)); cycle(1'b1, 1'b0);

        // Back-to-back write then read on one port
        drv(0, 1'b0, 1'b1, 1'b0, 10'd5, 8'h3C); cycle(1'b1, 1'b0);
        drv(0, 1'b0, 1'b1, 1'b1, 10'd5, 8'h00); cycle(1'b1, 1'b0);
        cmp(0, "R8", 1'b1, 8'h3C);
        chk(0, "R4");
        drv(1, 1'b0, 1'b1, 1'b1, 10'd5, 8'h00); cycle(1'b0, 1'b1);
        cmp(1, "R7", 1'b1, 8'h3C);

        // Asynchronous output enable
        poe[0] = 1'b1; #1;
        cmp(0, "R3", 1'b0, '0);
        poe[0] = 1'b0; #1;
        cmp(0, "R3", 1'b1, 8'h3C);

        // Deselected edges: no store, no launch
        drv(0, 1'b1, 1'b1, 1'b0, 10'd5, 8'hFF); cycle(1'b1, 1'b0);
        cmp(0, "R1", 1'b0, '0);
        drv(0, 1'b0, 1'b0, 1'b0, 10'd5, 8'hFF); cycle(1'b1, 1'b0);
        cmp(0, "R1", 1'b0, '0);
        drv(0, 1'b0, 1'b1, 1'b1, 10'd5, 8'h00); cycle(1'b1, 1'b0);
        cmp(0, "R1", 1'b1, 8'h3C);

        // Pipelined latency on port B
        drv(1, 1'b1, 1'b0, 1'b1, 10'd0, 8'h00); cycle(1'b0, 1'b1);
        ppipe[1] = 1'b1;
        drv(1, 1'b0, 1'b1, 1'b1, 10'd9, 8'h00); cycle(1'b0, 1'b1);
        cmp(1, "R5", 1'b0, '0);
        drv(1, 1'b1, 1'b0, 1'b1, 10'd0, 8'h00); cycle(1'b0, 1'b1);
        cmp(1, "R5", 1'b1, fill(9));
        ppipe[1] = 1'b0;

        // Same-instant write on A and read on B
        drv(0, 1'b0, 1'b1, 1'b0, 10'd7, 8'h11);
        drv(1, 1'b0, 1'b1, 1'b1, 10'd7, 8'h00);
        cycle(1'b1, 1'b1);
        cmp(1, "R9", 1'b1, fill(7));
        cycle(1'b0, 1'b1);
        cmp(1, "R9", 1'b1, 8'h11);

        // Mode pin switches output between edges
        drv(0, 1'b0, 1'b1, 1'b1, 10'd5, 8'h00); cycle(1'b1, 1'b0);
        drv(0, 1'b0, 1'b1, 1'b1, 10'd7, 8'h00); cycle(1'b1, 1'b0);
        cmp(0, "R6", 1'b1, 8'h11);
        ppipe[0] = 1'b1; #1;
        cmp(0, "R6", 1'b1, 8'h3C);
        ppipe[0] = 1'b0; #1;

        // Highest address written from B, read from A
        drv(1, 1'b0, 1'b1, 1'b0, AW'(DEPTH-1), 8'hA5); cycle(1'b0, 1'b1);
        drv(0, 1'b0, 1'b1, 1'b1, AW'(DEPTH-1), 8'h00); cycle(1'b1, 1'b0);
        cmp(0, "R2", 1'b1, 8'hA5);
        chk(0, "R7");

        // Random phases, modes, enables and collisions
        for (int i = 0; i < 4000; i++) begin
            bit ea, eb;
            int k;
            k = int'($urandom_range(2, 0));
            ea = (k != 1); eb = (k != 0);
            for (int p = 0; p < 2; p++) begin
                drv(p, ($urandom_range(9, 0) == 0), ($urandom_range(9, 0) != 0),
                    $urandom_range(2, 0) != 0, AW'($urandom_range(15, 0)), DW'($urandom));
                poe[p] = ($urandom_range(7, 0) == 0);
                if ($urandom_range(15, 0) == 0) ppipe[p] = !ppipe[p];
            end
            if (ea && eb && !prw[0] && !prw[1] && paddr[0] == paddr[1]) prw[1] = 1'b1;
            cycle(ea, eb);
            for (int p = 0; p < 2; p++) chk(p, ppipe[p] ? "R5" : "R4");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule